// File: doc/BRIEF.md
# Dual-Port Serial Configuration Register File

This block holds four 8-bit configuration registers that software-side hosts can only write. The registers can be loaded over two serial paths. One is a 3-wire port with a select, a clock and a data line. The other is a write-only I2C slave. A mode input picks the active path, and the path that is not selected has no effect. All inputs are already synchronous to the fast system clock. The block samples them and finds their edges internally. All four registers are always visible on one flat parallel output.

A 3-wire transfer is a fixed 16-bit frame. It is committed only when the select line returns high. An I2C transfer carries a device address byte, then a register pointer byte, then any number of data bytes. The pointer advances after each data byte and wraps back to the first register. Register 01h bit 7 is a self-clearing command that returns the whole file to its power-on image. Register 00h bit 0 is ordinary storage, and downstream timing logic uses it.

Top module: `serial_cfg_regs`

## Requirements
- R1: After reset the flat output `regs` reads 32'h000F_0289: register 0 = 89h in bits 7:0, register 1 = 02h in bits 15:8, register 2 = 0Fh in bits 23:16, register 3 = 00h in bits 31:24.
- R2: In 3-wire mode (`i2c_mode`=0), the block shifts in `tw_dat` MSB first on each rising `tw_clk` while `tw_cs_n` is low. The frame layout is: bits 15:14 chip code, bit 13 write flag, bits 12:8 register address, bits 7:0 data. The register is updated only after `tw_cs_n` rises.
- R3: A 3-wire frame whose chip code is not 2'b11, or whose write flag is 0, leaves every register unchanged.
- R4: A 3-wire frame with fewer or more than 16 rising clock edges while select is low leaves every register unchanged.
- R5: In I2C mode the first byte after START is accepted only if it equals {6'b001001, `dev_sel`, 1'b0}. An accepted byte is acknowledged by raising `sda_oe` during the ninth SCL pulse. Any other first byte, including one with the R/W bit set to 1, gets no acknowledge and causes no write until the next START.
- R6: The second I2C byte is the register pointer. It is acknowledged only when its top three bits are zero, and its low five bits become the pointer. Each following byte is acknowledged and written at the pointer.
- R7: After each I2C data byte the pointer steps by one. A pointer at 03h or higher wraps to 00h, so a long burst overwrites earlier registers.
- R8: A write that sets bit 7 of register 01h is visible for one clock. On the next clock all four registers return to their R1 values.
- R9: Writes to register addresses 04h to 1Fh are accepted (acknowledged in I2C mode) but change no register.
- R10: Bit 0 of register 00h is stored like any other bit. Writing it alters only register 00h.
- R11: The port not selected by `i2c_mode` has no effect on the registers. `sda_oe` stays low in 3-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2c_mode | input | 1 | 1 selects the I2C port, 0 selects the 3-wire port |
| dev_sel | input | 1 | Low bit of the I2C device address |
| tw_cs_n | input | 1 | 3-wire select, active low |
| tw_clk | input | 1 | 3-wire shift clock |
| tw_dat | input | 1 | 3-wire serial data |
| scl | input | 1 | I2C clock level |
| sda_in | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| regs | output | 32 | Register file, register n in bits 8n+7:8n |

## Verification
The hardest state to reach is the pointer wrap that happens while the pointer is outside the implemented range. It only occurs when an I2C burst starts at an unused address, so that the first data byte is acknowledged but discarded and the second lands in register 00h. The bench drives exactly such a burst with pointer 07h. The one-clock glimpse of the reset command bit is also hard to see from outside. A bound property watches for it, while the bench confirms the full default image afterwards.

// File: rtl/srw_pkg.sv
package srw_pkg;
    parameter int DW    = 8;
    parameter int AW    = 5;
    parameter int NREG  = 4;

    localparam logic [5:0] I2C_DEV_PREFIX = 6'b001001;
    localparam logic [1:0] TW_CHIP_CODE   = 2'b11;
    localparam int         RST_REG        = 1;
    localparam int         RST_BIT        = 7;

    function automatic logic [DW-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h89;
            1:       return 8'h02;
            2:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NREG*DW-1:0] file_default();
        logic [NREG*DW-1:0] img;
        img = '0;
        for (int i = 0; i < NREG; i++) begin
            img[i*DW +: DW] = reg_default(i);
        end
        return img;
    endfunction
endpackage

// File: rtl/srw_tw_rx.sv
module srw_tw_rx
    import srw_pkg::*;
#(
    parameter int P_DW = DW,
    parameter int P_AW = AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            sdat,
    output logic            wr_en,
    output logic [P_AW-1:0] wr_addr,
    output logic [P_DW-1:0] wr_data
);
    localparam int FRAME = 3 + P_AW + P_DW;
    localparam int CW    = $clog2(FRAME + 2);

    typedef struct packed {
        logic             cs_q;
        logic             clk_q;
        logic [FRAME-1:0] shift;
        logic [CW-1:0]    cnt;
        logic             wr_en;
        logic [P_AW-1:0]  wr_addr;
        logic [P_DW-1:0]  wr_data;
    } tw_state_t;

    tw_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cs_q  = cs_n;
        st_d.clk_q = sclk;
        st_d.wr_en = 1'b0;
        if (st_q.cs_q && !cs_n) begin
            st_d.cnt = '0;
        end else if (!cs_n && sclk && !st_q.clk_q) begin
            st_d.shift = {st_q.shift[FRAME-2:0], sdat};
            if (st_q.cnt != CW'(FRAME + 1)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (!st_q.cs_q && cs_n && en
            && st_q.cnt == CW'(FRAME)
            && st_q.shift[FRAME-1 -: 2] == TW_CHIP_CODE
            && st_q.shift[FRAME-3]) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_addr = st_q.shift[P_DW +: P_AW];
            st_d.wr_data = st_q.shift[P_DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.wr_addr;
    assign wr_data = st_q.wr_data;
endmodule

// File: rtl/srw_i2c_rx.sv
module srw_i2c_rx
    import srw_pkg::*;
#(
    parameter int P_DW   = DW,
    parameter int P_AW   = AW,
    parameter int P_NREG = NREG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            dev_sel,
    input  logic            scl,
    input  logic            sda,
    output logic            ack_oe,
    output logic            wr_en,
    output logic [P_AW-1:0] wr_addr,
    output logic [P_DW-1:0] wr_data
);
    localparam int BCW = $clog2(P_DW + 1);

    typedef enum logic [1:0] {S_IDLE, S_RECV, S_ACK, S_SKIP} bus_st_t;
    typedef enum logic [1:0] {PH_DEV, PH_PTR, PH_DATA}       phase_t;

    typedef struct packed {
        logic            scl_q;
        logic            sda_q;
        bus_st_t         st;
        phase_t          ph;
        logic [P_DW-1:0] shift;
        logic [BCW-1:0]  bits;
        logic [P_AW-1:0] ptr;
        logic            ack;
        logic            wr_en;
        logic [P_AW-1:0] wr_addr;
        logic [P_DW-1:0] wr_data;
    } i2c_state_t;

    i2c_state_t st_d, st_q;

    logic scl_rise, scl_fall, bus_start, bus_stop;

    always_comb begin
        scl_rise  = scl && !st_q.scl_q;
        scl_fall  = !scl && st_q.scl_q;
        bus_start = scl && st_q.scl_q && st_q.sda_q && !sda;
        bus_stop  = scl && st_q.scl_q && !st_q.sda_q && sda;

        st_d       = st_q;
        st_d.scl_q = scl;
        st_d.sda_q = sda;
        st_d.wr_en = 1'b0;

        if (!en) begin
            st_d.st  = S_IDLE;
            st_d.ack = 1'b0;
        end else if (bus_start) begin
            st_d.st   = S_RECV;
            st_d.ph   = PH_DEV;
            st_d.bits = '0;
            st_d.ack  = 1'b0;
        end else if (bus_stop) begin
            st_d.st  = S_IDLE;
            st_d.ack = 1'b0;
        end else begin
            case (st_q.st)
                S_RECV: begin
                    if (scl_rise && st_q.bits != BCW'(P_DW)) begin
                        st_d.shift = {st_q.shift[P_DW-2:0], sda};
                        st_d.bits  = st_q.bits + 1'b1;
                    end else if (scl_fall && st_q.bits == BCW'(P_DW)) begin
                        case (st_q.ph)
                            PH_DEV: begin
                                if (st_q.shift[P_DW-1:1] == {I2C_DEV_PREFIX, dev_sel}
                                    && !st_q.shift[0]) begin
                                    st_d.st  = S_ACK;
                                    st_d.ack = 1'b1;
                                    st_d.ph  = PH_PTR;
                                end else begin
                                    st_d.st = S_SKIP;
                                end
                            end
                            PH_PTR: begin
                                if (st_q.shift[P_DW-1:P_AW] == '0) begin
                                    st_d.ptr = st_q.shift[P_AW-1:0];
                                    st_d.st  = S_ACK;
                                    st_d.ack = 1'b1;
                                    st_d.ph  = PH_DATA;
                                end else begin
                                    st_d.st = S_SKIP;
                                end
                            end
                            default: begin
                                st_d.wr_en   = 1'b1;
                                st_d.wr_addr = st_q.ptr;
                                st_d.wr_data = st_q.shift;
                                st_d.ptr     = (st_q.ptr >= P_AW'(P_NREG - 1))
                                               ? '0 : st_q.ptr + 1'b1;
                                st_d.st      = S_ACK;
                                st_d.ack     = 1'b1;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        st_d.ack  = 1'b0;
                        st_d.st   = S_RECV;
                        st_d.bits = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.st    <= S_IDLE;
            st_q.ph    <= PH_DEV;
            st_q.scl_q <= 1'b1;
            st_q.sda_q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_oe  = st_q.ack;
    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.wr_addr;
    assign wr_data = st_q.wr_data;
endmodule

// File: rtl/srw_regbank.sv
module srw_regbank
    import srw_pkg::*;
#(
    parameter int P_DW   = DW,
    parameter int P_AW   = AW,
    parameter int P_NREG = NREG
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [P_AW-1:0]        wr_addr,
    input  logic [P_DW-1:0]        wr_data,
    output logic [P_NREG*P_DW-1:0] regs
);
    localparam int IW = (P_NREG > 1) ? $clog2(P_NREG) : 1;

    typedef struct packed {
        logic [P_NREG-1:0][P_DW-1:0] r;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [P_NREG*P_DW-1:0] dflt;

    assign dflt = file_default();

    always_comb begin
        bk_d = bk_q;
        if (bk_q.r[RST_REG][RST_BIT]) begin
            bk_d.r = dflt;
        end else if (wr_en && wr_addr < P_AW'(P_NREG)) begin
            bk_d.r[wr_addr[IW-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q.r <= dflt;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign regs = bk_q.r;
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
    import srw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               i2c_mode,
    input  logic               dev_sel,
    input  logic               tw_cs_n,
    input  logic               tw_clk,
    input  logic               tw_dat,
    input  logic               scl,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NREG*DW-1:0] regs
);
    logic          tw_wr_en,  i2_wr_en,  wr_en;
    logic [AW-1:0] tw_wr_addr, i2_wr_addr, wr_addr;
    logic [DW-1:0] tw_wr_data, i2_wr_data, wr_data;

    srw_tw_rx u_tw (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!i2c_mode),
        .cs_n    (tw_cs_n),
        .sclk    (tw_clk),
        .sdat    (tw_dat),
        .wr_en   (tw_wr_en),
        .wr_addr (tw_wr_addr),
        .wr_data (tw_wr_data)
    );

    srw_i2c_rx u_i2c (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (i2c_mode),
        .dev_sel (dev_sel),
        .scl     (scl),
        .sda     (sda_in),
        .ack_oe  (sda_oe),
        .wr_en   (i2_wr_en),
        .wr_addr (i2_wr_addr),
        .wr_data (i2_wr_data)
    );

    always_comb begin
        if (i2c_mode) begin
            wr_en   = i2_wr_en;
            wr_addr = i2_wr_addr;
            wr_data = i2_wr_data;
        end else begin
            wr_en   = tw_wr_en;
            wr_addr = tw_wr_addr;
            wr_data = tw_wr_data;
        end
    end

    srw_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );
endmodule

// File: rtl/chk_serial_cfg_regs.sv
module chk_serial_cfg_regs
    import srw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               i2c_mode,
    input logic               scl,
    input logic               sda_oe,
    input logic [NREG*DW-1:0] regs,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr
);
    localparam int CMD_POS = RST_REG * DW + RST_BIT;

    AST_SDA_QUIET_3W: assert property (@(posedge clk) disable iff (!rst_n)
        (!i2c_mode && !$past(i2c_mode)) |-> !sda_oe); // R11

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl); // R5

    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        regs[CMD_POS] |=> (regs == file_default())); // R8

    AST_HIGH_ADDR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= AW'(NREG) && !regs[CMD_POS]) |=> $stable(regs)); // R9

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !regs[CMD_POS]) |=> $stable(regs)); // R10
endmodule

bind serial_cfg_regs chk_serial_cfg_regs u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .i2c_mode (i2c_mode),
    .scl      (scl),
    .sda_oe   (sda_oe),
    .regs     (regs),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
);

// File: tb/test_serial_cfg_regs.sv
`timescale 1ns/1ps
module test_serial_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i2c_mode = 1'b0;
    logic        dev_sel = 1'b1;
    logic        tw_cs_n = 1'b1, tw_clk = 1'b0, tw_dat = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [31:0] regs;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  em[4];

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    serial_cfg_regs i_serial_cfg_regs (
        .clk(clk), .rst_n(rst_n), .i2c_mode(i2c_mode), .dev_sel(dev_sel),
        .tw_cs_n(tw_cs_n), .tw_clk(tw_clk), .tw_dat(tw_dat),
        .scl(m_scl), .sda_in(sda_line), .sda_oe(sda_oe), .regs(regs)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] want);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic model_reset();
        em[0] = 8'h89; em[1] = 8'h02; em[2] = 8'h0F; em[3] = 8'h00;
    endtask

    task automatic model_write(input int addr, input logic [7:0] d);
        if (addr < 4) begin
            em[addr] = d;
            if (addr == 1 && d[7]) model_reset();
        end
    endtask

    task automatic expect_regs(input string tag);
        repeat (4) @(negedge clk);
        exp_q.push_back({em[3], em[2], em[1], em[0]});
        tag_q.push_back(tag);
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                logic [31:0] want;
                string t;
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                check(regs == want, t, regs, want);
            end
        end
    end

    task automatic tw_frame(input logic [15:0] f, input int nclk);
        tw_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            tw_dat = (i < 16) ? f[15-i] : 1'b0;
            repeat (2) @(negedge clk);
            tw_clk = 1'b1;
            repeat (2) @(negedge clk);
            tw_clk = 1'b0;
        end
        repeat (2) @(negedge clk);
        tw_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; m_scl = 1'b1;
        repeat (4) @(negedge clk);
        m_sda = 1'b0;
        repeat (4) @(negedge clk);
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0;
        repeat (2) @(negedge clk);
        m_scl = 1'b1;
        repeat (4) @(negedge clk);
        m_sda = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic i2c_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            repeat (2) @(negedge clk);
            m_scl = 1'b1;
            repeat (4) @(negedge clk);
            m_scl = 1'b0;
            repeat (2) @(negedge clk);
        end
        m_sda = 1'b1;
        repeat (2) @(negedge clk);
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        check(sda_oe == exp_ack, tag, {31'b0, sda_oe}, {31'b0, exp_ack});
        repeat (2) @(negedge clk);
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] tw_word(input logic [1:0] chip, input logic w,
                                            input logic [4:0] a, input logic [7:0] d);
        return {chip, w, a, d};
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_regs("R1 reset image");

        // 3-wire path
        tw_frame(tw_word(2'b11, 1'b1, 5'd2, 8'hA5), 16); model_write(2, 8'hA5);
        expect_regs("R2 3-wire write reg2");
        tw_frame(tw_word(2'b11, 1'b1, 5'd3, 8'h3C), 16); model_write(3, 8'h3C);
        expect_regs("R2 3-wire write reg3");
        tw_frame(tw_word(2'b10, 1'b1, 5'd3, 8'hFF), 16);
        expect_regs("R3 bad chip code");
        tw_frame(tw_word(2'b11, 1'b0, 5'd3, 8'hFF), 16);
        expect_regs("R3 write flag clear");
        tw_frame(tw_word(2'b11, 1'b1, 5'd2, 8'h11), 15);
        expect_regs("R4 short frame");
        tw_frame(tw_word(2'b11, 1'b1, 5'd2, 8'h11), 17);
        expect_regs("R4 long frame");
        tw_frame(tw_word(2'b11, 1'b1, 5'd5, 8'h77), 16);
        expect_regs("R9 3-wire high address");
        tw_frame(tw_word(2'b11, 1'b1, 5'd0, 8'h88), 16); model_write(0, 8'h88);
        expect_regs("R10 reg0 bit0 cleared");

        // I2C traffic while in 3-wire mode
        i2c_start();
        i2c_byte(8'h26, 1'b0, "R11 no ack in 3-wire mode");
        i2c_byte(8'h02, 1'b0, "R11 no ack in 3-wire mode");
        i2c_byte(8'h11, 1'b0, "R11 no ack in 3-wire mode");
        i2c_stop();
        expect_regs("R11 I2C ignored in 3-wire mode");

        // I2C path
        i2c_mode = 1'b1;
        repeat (4) @(negedge clk);
        i2c_start();
        i2c_byte(8'h26, 1'b1, "R5 device address ack");
        i2c_byte(8'h01, 1'b1, "R6 pointer ack");
        i2c_byte(8'h40, 1'b1, "R6 data ack");
        i2c_stop(); model_write(1, 8'h40);
        expect_regs("R6 I2C single write");

        i2c_start();
        i2c_byte(8'h26, 1'b1, "R5 device address ack");
        i2c_byte(8'h02, 1'b1, "R6 pointer ack");
        i2c_byte(8'h01, 1'b1, "R7 burst ack");
        i2c_byte(8'h02, 1'b1, "R7 burst ack");
        i2c_byte(8'h03, 1'b1, "R7 burst ack");
        i2c_stop();
        model_write(2, 8'h01); model_write(3, 8'h02); model_write(0, 8'h03);
        expect_regs("R7 burst wraps to reg0");

        i2c_start();
        i2c_byte(8'h24, 1'b0, "R5 wrong device address nack");
        i2c_byte(8'h01, 1'b0, "R5 silent after mismatch");
        i2c_byte(8'h55, 1'b0, "R5 silent after mismatch");
        i2c_stop();
        expect_regs("R5 mismatch writes nothing");

        i2c_start();
        i2c_byte(8'h27, 1'b0, "R5 read request nack");
        i2c_stop();
        expect_regs("R5 read request writes nothing");

        i2c_start();
        i2c_byte(8'h26, 1'b1, "R5 device address ack");
        i2c_byte(8'h21, 1'b0, "R6 pointer top bits nack");
        i2c_stop();
        expect_regs("R6 bad pointer writes nothing");

        i2c_start();
        i2c_byte(8'h26, 1'b1, "R5 device address ack");
        i2c_byte(8'h07, 1'b1, "R9 high pointer ack");
        i2c_byte(8'h99, 1'b1, "R9 high address data ack");
        i2c_byte(8'h5A, 1'b1, "R7 wrap from high pointer ack");
        i2c_stop();
        model_write(7, 8'h99); model_write(0, 8'h5A);
        expect_regs("R9 discard then R7 wrap");

        tw_frame(tw_word(2'b11, 1'b1, 5'd3, 8'hEE), 16);
        expect_regs("R11 3-wire ignored in I2C mode");

        i2c_start();
        i2c_byte(8'h26, 1'b1, "R5 device address ack");
        i2c_byte(8'h01, 1'b1, "R6 pointer ack");
        i2c_byte(8'h80, 1'b1, "R8 command ack");
        i2c_stop(); model_write(1, 8'h80);
        expect_regs("R8 defaults restored");

        repeat (10) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule